// File: doc/BRIEF.md
# Host Controller Interrupt Mask and Status Block

This block keeps the interrupt masking state and the pending event flags of a host controller. A single 32-bit enable word is reached through two command codes. One code turns enable bits on wherever the written data holds a one. The other turns enable bits off wherever the written data holds a one. Both codes read back the same live enable word, so software never has to read, modify and write the word to change one source.

A set of sticky status flags records one-cycle event pulses from the rest of the controller. Software clears a flag by writing a one to it. Bit 31 of the enable word is a master switch. One registered interrupt line is raised while the master switch is on and at least one pending flag has its own enable bit set.

Top module: `hc_irq_ctrl`

## Requirements
- R1: After reset the enable word, all status flags and `irq_o` are 0.
- R2: A write with code 0x84 sets each enable bit whose data bit is 1. A data bit of 0 leaves that enable bit unchanged.
- R3: A write with code 0x85 clears each enable bit whose data bit is 1. A data bit of 0 leaves that enable bit unchanged.
- R4: Codes 0x04 and 0x05 both return the current enable word on `rd_data` in the same cycle. A code with bit 7 clear is a read only and changes no state, even with `cmd_valid` high.
- R5: Only these enable bits can be written: 31 (master), 6, 5, 4, 3, 2 and 0. Every other bit, including bit 1, ignores writes and reads as 0. The writable mask is 0x8000007D.
- R6: A one-cycle pulse on `evt_i[k]` sets status bit k for k in {0,2,3,4,5,6}. A pulse on `evt_i[1]` is ignored. Code 0x03 returns the status word.
- R7: A write with code 0x83 clears each status bit whose data bit is 1. Status bits written with 0 are unchanged.
- R8: If an event pulse and a 0x83 clear of the same bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` is 1 when bit 31 of the enable word is 1 and any status bit is 1 whose enable bit is also 1. It is registered and follows that condition one clock later.
- R10: Clearing bit 31 with code 0x85 blocks the interrupt from every source, whatever the status and the other enable bits hold.
- R11: Any other command code reads as 0 and has no effect when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Qualifies a write for codes with bit 7 set |
| cmd_code | input | 8 | Command code selecting the register view |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `cmd_code`, combinational |
| evt_i | input | 7 | One-cycle event pulses, one per source bit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Read data is combinational from `cmd_code`. A write or an event pulse shows in `rd_data` right after the clock edge that takes it. The bench drives on falling edges and samples on the next falling edge, once that edge is past. `irq_o` has one more register, so it follows a status or enable change one edge later. The interrupt checks sample both the falling edge right after the change, where the old value must still show, and the one after that, where the new value must show.

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl #(
  parameter int          DW       = 32,
  parameter int          EW       = 7,
  parameter int          MIE_BIT  = 31,
  parameter logic [31:0] SRC_MASK = 32'h0000_007D,
  parameter logic [7:0]  CODE_STS = 8'h03,
  parameter logic [7:0]  CODE_ENA = 8'h04,
  parameter logic [7:0]  CODE_DIS = 8'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [EW-1:0] evt_i,
  output logic          irq_o
);

  localparam logic [7:0]    WR_FLAG = 8'h80;
  localparam logic [DW-1:0] SRC_M   = SRC_MASK[DW-1:0];
  localparam logic [DW-1:0] EN_MASK = SRC_M | (DW'(1) << MIE_BIT);

  logic [DW-1:0] en_q, sts_q, evt_ext;
  logic          wr_set, wr_clr, wr_sts;

  assign wr_set  = cmd_valid && (cmd_code == (CODE_ENA | WR_FLAG));
  assign wr_clr  = cmd_valid && (cmd_code == (CODE_DIS | WR_FLAG));
  assign wr_sts  = cmd_valid && (cmd_code == (CODE_STS | WR_FLAG));
  assign evt_ext = DW'(evt_i) & SRC_M;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_set) begin
      en_q <= en_q | (wr_data & EN_MASK);
    end else if (wr_clr) begin
      en_q <= en_q & ~(wr_data & EN_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~(wr_sts ? wr_data : '0)) | evt_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= en_q[MIE_BIT] & |(sts_q & en_q & SRC_M);
  end

  always_comb begin
    case (cmd_code)
      CODE_STS:           rd_data = sts_q;
      CODE_ENA, CODE_DIS: rd_data = en_q;
      default:            rd_data = '0;
    endcase
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) $past(!rst_n) |-> (en_q == '0 && sts_q == '0 && !irq_o)); // R1
  AST_SET_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(wr_data & EN_MASK)) == $past(wr_data & EN_MASK))); // R2
  AST_CLR_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(wr_data)) == '0)); // R3
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~EN_MASK) == '0) && ((sts_q & ~SRC_M) == '0)); // R5
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ext != '0) |=> ((sts_q & $past(evt_ext)) == $past(evt_ext))); // R8
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[MIE_BIT] |=> !irq_o); // R10
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(en_q)); // R11

endmodule

// File: tb/hc_irq_ctrl_tb.sv
`timescale 1ns/1ps
module hc_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [6:0]  evt_i = '0;
  logic        irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  hc_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_data(wr_data), .rd_data(rd_data), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] d);
    cmd_code = code;
    #0.5;
    d = rd_data;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); check("R1 enable", d, 32'h0);
    rd(8'h03, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_enable_views();
    logic [31:0] d;
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R5 set all", d, 32'h8000_007D);
    rd(8'h05, d); check("R4 disable view readback", d, 32'h8000_007D);
    wr(8'h85, 32'h0000_0000);
    rd(8'h04, d); check("R3 zero clear", d, 32'h8000_007D);
    wr(8'h85, 32'h0000_000C);
    rd(8'h05, d); check("R3 clear bits", d, 32'h8000_0071);
    wr(8'h84, 32'h0000_0000);
    rd(8'h04, d); check("R2 zero set", d, 32'h8000_0071);
    wr(8'h84, 32'h0000_0008);
    rd(8'h04, d); check("R2 set bit", d, 32'h8000_0079);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R4 read code no write", d, 32'h8000_0079);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(8'h85, 32'h8000_0000);
    pulse(7'h7F);
    rd(8'h03, d); check("R6 events", d, 32'h0000_007D);
    wr(8'h83, 32'h0000_0011);
    rd(8'h03, d); check("R7 clear", d, 32'h0000_006C);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h83; wr_data = 32'h0000_0004; evt_i = 7'h04;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0; evt_i = '0;
    rd(8'h03, d); check("R8 set wins", d, 32'h0000_006C);
    wr(8'h83, 32'hFFFF_FFFF);
    rd(8'h03, d); check("R7 clear all", d, 32'h0);
  endtask

  task automatic t_irq();
    wr(8'h85, 32'hFFFF_FFFF);
    wr(8'h84, 32'h8000_0004);
    pulse(7'h20);
    @(negedge clk);
    check("R9 unenabled source", {31'b0, irq_o}, 32'h0);
    pulse(7'h04);
    check("R9 irq one edge late", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 irq raised", {31'b0, irq_o}, 32'h1);
    wr(8'h85, 32'h8000_0000);
    check("R10 irq still old", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R10 master blocks", {31'b0, irq_o}, 32'h0);
    wr(8'h84, 32'h0000_0020);
    @(negedge clk);
    check("R10 still blocked", {31'b0, irq_o}, 32'h0);
    wr(8'h84, 32'h8000_0000);
    @(negedge clk);
    check("R9 master back", {31'b0, irq_o}, 32'h1);
    wr(8'h83, 32'h0000_0024);
    @(negedge clk);
    check("R9 cleared drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_unknown();
    logic [31:0] d;
    pulse(7'h08);
    wr(8'h86, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'hFF, 32'hFFFF_FFFF);
    rd(8'h86, d); check("R11 unknown reads 0", d, 32'h0);
    rd(8'h10, d); check("R11 unknown reads 0b", d, 32'h0);
    rd(8'h04, d); check("R11 enable kept", d, 32'h8000_0024);
    rd(8'h03, d); check("R11 status kept", d, 32'h0000_0008);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_views();
    t_status();
    t_irq();
    t_unknown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule